// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block produces every timing strobe a multi-rate audio path needs from one fixed 27 MHz master clock. It has no second crystal and no analog loop. A phase accumulator adds a per-mode denominator D on every master cycle. Each time the sum reaches the numerator N, it wraps and emits a one-cycle enable. The average strobe rate is therefore exactly 27 MHz x D / N, which is 256 times the selected sample rate. Binary counters on that strobe give the 128fs, fs and left/right frame timing. A second accumulator, stepping by 2D, gives 512fs.

A rate select picks one of five base ratios. A half-rate flag doubles N. A wide-pair flag, honoured only together with half-rate, moves the two paired outputs from the 128x/256x pair to the 256x/512x pair. Every output is a clock enable in the master domain. Any change to the three configuration inputs restarts all timing from phase zero, so downstream PCM or S/PDIF logic never sees a strobe built from a mix of two ratios.

Top module: `audclk_gen`

## Requirements
- R1: While reset (rst_n low, sampled on the clock edge) is asserted, all strobe outputs, both pair outputs and lr_frame are low.
- R2: With half_rate=0, ena_256 pulses exactly D times in any N consecutive master cycles. The ratios N/D for rate_sel are: 0 gives 1125/512, 1 gives 1875/784, 2 gives 2145/896, 3 gives 3375/1024, 4 (synchronous) gives 2/1. Codes 5 to 7 behave as code 0.
- R3: Two ena_256 pulses are never closer together than floor(N/D) cycles, and never fall on adjacent cycles.
- R4: With half_rate=1, N is doubled and D is unchanged, so ena_256 pulses D times in any 2N consecutive cycles.
- R5: In synchronous mode (rate_sel=4, half_rate=0), ena_256 is high on every second master cycle.
- R6: ena_128 is high on every second ena_256 pulse and never without one.
- R7: ena_fs is high on every 256th ena_256 pulse. lr_frame toggles in exactly the cycles where ena_fs is high.
- R8: When half_rate=1 and wide_pair=1, pair_lo follows ena_256 and pair_hi follows ena_512, which pulses 2D times per 2N cycles. Otherwise pair_lo follows ena_128 and pair_hi follows ena_256.
- R9: ena_512 stays low unless both half_rate and wide_pair are 1.
- R10: In the cycle after any change of rate_sel, half_rate or wide_pair, every strobe is low. Accumulators and counters then restart from zero, so with N=4 and D=1 the first new ena_256 pulse comes 4 cycles after that quiet cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | Base ratio select (0..4) |
| half_rate | input | 1 | Doubles the ratio numerator |
| wide_pair | input | 1 | Chooses the 256x/512x pair when half_rate is set |
| ena_512 | output | 1 | 512fs enable strobe |
| ena_256 | output | 1 | 256fs enable strobe |
| ena_128 | output | 1 | 128fs enable strobe |
| ena_fs | output | 1 | Sample-rate enable strobe |
| lr_frame | output | 1 | Left/right frame flag |
| pair_lo | output | 1 | Lower strobe of the selected pair |
| pair_hi | output | 1 | Upper strobe of the selected pair |

## Verification
The bench measures each mode over a window of exactly N (or 2N) cycles and counts the pulses. A wrong ratio constant, a missing numerator doubling or an off-by-one in the wrap compare would shift that count away from D. It tracks the smallest pulse gap, which catches an accumulator that wraps early or emits two strobes back to back. It counts pulses on the sub-rate outputs and toggles on lr_frame, which exposes a divider that taps the wrong counter bit or a frame flag that drifts from ena_fs. It also toggles the configuration while the synchronous mode is running. This checks the quiet cycle and the exact position of the first new pulse, which a design that kept its old phase would miss.

// File: rtl/audclk_pkg.sv
// Shared constants and the ratio lookup for the fractional audio clock generator.
// Assumes: the numerator never exceeds 2^(RATIO_W-1) after half-rate doubling.
package audclk_pkg;

    localparam int RATIO_W = 14;

    typedef struct packed {
        logic [RATIO_W-1:0] num;
        logic [RATIO_W-1:0] den;
    } ratio_t;

    // Base (full-rate) N/D for a rate code; unknown codes fall back to 48 kHz.
    function automatic ratio_t base_ratio(input logic [2:0] code);
        ratio_t r;
        case (code)
            3'd1:    begin r.num = RATIO_W'(1875); r.den = RATIO_W'(784);  end
            3'd2:    begin r.num = RATIO_W'(2145); r.den = RATIO_W'(896);  end
            3'd3:    begin r.num = RATIO_W'(3375); r.den = RATIO_W'(1024); end
            3'd4:    begin r.num = RATIO_W'(2);    r.den = RATIO_W'(1);    end
            default: begin r.num = RATIO_W'(1125); r.den = RATIO_W'(512);  end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audclk_ratio.sv
// Ratio selector: maps the rate code and half-rate flag to the N/D pair.
// Assumes: the half-rate doubling does not overflow W bits.
module audclk_ratio
    import audclk_pkg::*;
#(
    parameter int W = RATIO_W
) (
    input  logic [2:0]   rate_sel,
    input  logic         half_rate,
    output logic [W-1:0] num,
    output logic [W-1:0] den
);
    ratio_t base;

    // Look up the base ratio, then double N for half-rate operation.
    always_comb begin
        base = base_ratio(rate_sel);
        num  = half_rate ? W'({base.num, 1'b0}) : W'(base.num);
        den  = W'(base.den);
    end
endmodule

// File: rtl/audclk_phase_acc.sv
// Rational phase accumulator: adds step every cycle and reports a hit (then
// wraps by num) whenever the sum reaches num.
// Assumes: step < num, so at most one hit per cycle; clr restarts from zero.
module audclk_phase_acc #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] num,
    input  logic [W-1:0] step,
    output logic         hit
);
    logic [W-1:0] acc;
    logic [W-1:0] sum;

    // Next phase and wrap detect from the current phase.
    always_comb begin
        sum = acc + step;
        hit = (sum >= num);
    end

    // Phase register: cleared on reset or restart, otherwise advanced modulo num.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (hit)      acc <= sum - num;
        else               acc <= sum;
    end
endmodule

// File: rtl/audclk_bin_div.sv
// Binary divider on an input tick: flags every second tick and every
// 2^CNT_W-th tick, both in the same cycle as the tick itself.
// Assumes: tick is a single-cycle enable; clr restarts the count at zero.
module audclk_bin_div #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic tick_div2,
    output logic tick_wrap
);
    logic [CNT_W-1:0] cnt;

    // Decode the divided ticks from the count before it advances.
    always_comb begin
        tick_div2 = tick & cnt[0];
        tick_wrap = tick & (&cnt);
    end

    // Tick counter with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/audclk_gen.sv
// Fractional audio clock generator top. It derives 512fs, 256fs, 128fs and fs
// enable strobes plus a left/right flag from one master clock, using rational
// phase accumulators. Any configuration change restarts all timing.
// Assumes: the configuration inputs are synchronous to clk; 2D < N in every
// mode where the 512fs path is enabled.
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int W      = RATIO_W,
    parameter int FS_DIV = 256,
    parameter bit HAS_X2 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    input  logic       half_rate,
    input  logic       wide_pair,
    output logic       ena_512,
    output logic       ena_256,
    output logic       ena_128,
    output logic       ena_fs,
    output logic       lr_frame,
    output logic       pair_lo,
    output logic       pair_hi
);
    localparam int CNT_W = $clog2(FS_DIV);
    localparam int CFG_W = 5;

    logic [CFG_W-1:0] cfg_now, cfg_q;
    logic             cfg_chg;
    logic             use_x2, use_x2_q;
    logic [W-1:0]     num, den;
    logic             hit_256, hit_512, hit_128, hit_fs;

    // Live configuration word, change detect and wide-pair qualifier.
    always_comb begin
        cfg_now = {rate_sel, half_rate, wide_pair};
        cfg_chg = (cfg_now != cfg_q);
        use_x2  = HAS_X2 && half_rate && wide_pair;
    end

    // Configuration history register; loads during reset so no false restart.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    audclk_ratio #(.W(W)) u_ratio (
        .rate_sel (rate_sel),
        .half_rate(half_rate),
        .num      (num),
        .den      (den)
    );

    audclk_phase_acc #(.W(W)) u_acc_256 (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cfg_chg),
        .num  (num),
        .step (den),
        .hit  (hit_256)
    );

    generate
        if (HAS_X2) begin : g_x2
            logic [W-1:0] step_x2;
            // Double step for the 512fs accumulator.
            always_comb step_x2 = {den[W-2:0], 1'b0};
            audclk_phase_acc #(.W(W)) u_acc_512 (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (cfg_chg || !use_x2),
                .num  (num),
                .step (step_x2),
                .hit  (hit_512)
            );
        end else begin : g_no_x2
            // No 512fs path in this variant.
            always_comb hit_512 = 1'b0;
        end
    endgenerate

    audclk_bin_div #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_chg),
        .tick     (hit_256),
        .tick_div2(hit_128),
        .tick_wrap(hit_fs)
    );

    // Registered strobes and frame flag; all silent in the restart cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_chg) begin
            ena_512  <= 1'b0;
            ena_256  <= 1'b0;
            ena_128  <= 1'b0;
            ena_fs   <= 1'b0;
            lr_frame <= 1'b0;
            use_x2_q <= 1'b0;
        end else begin
            ena_512  <= hit_512 && use_x2;
            ena_256  <= hit_256;
            ena_128  <= hit_128;
            ena_fs   <= hit_fs;
            lr_frame <= lr_frame ^ hit_fs;
            use_x2_q <= use_x2;
        end
    end

    // Output pair steering from the registered wide-pair state.
    always_comb begin
        pair_lo = use_x2_q ? ena_256 : ena_128;
        pair_hi = use_x2_q ? ena_512 : ena_256;
    end
endmodule

// File: rtl/audclk_gen_chk.sv
// Protocol checker for audclk_gen, attached through bind.
// Assumes: only port-level signals are observed.
module audclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] rate_sel,
    input logic       half_rate,
    input logic       wide_pair,
    input logic       ena_512,
    input logic       ena_256,
    input logic       ena_128,
    input logic       ena_fs,
    input logic       lr_frame
);
    // R3: no two 256fs strobes on adjacent cycles.
    p_gap_256_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ena_256 |=> !ena_256);

    // R8: the 512fs strobe also never fires on adjacent cycles.
    p_gap_512_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ena_512 |=> !ena_512);

    // R6: 128fs only together with 256fs.
    p_sub_128_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ena_128 |-> ena_256);

    // R7: fs only together with 128fs.
    p_sub_fs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ena_fs |-> ena_128);

    // R7: the frame flag flips on every fs strobe.
    p_lr_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ena_fs |-> (lr_frame != $past(lr_frame)));

    // R9: 512fs is off unless half-rate and wide pair are both selected.
    p_x2_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(half_rate && wide_pair) |=> !ena_512);

    // R10: a configuration change is followed by a cycle with no strobe.
    p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_sel != $past(rate_sel)) || (half_rate != $past(half_rate)) ||
         (wide_pair != $past(wide_pair)))
        |=> !(ena_256 || ena_128 || ena_512 || ena_fs));
endmodule

bind audclk_gen audclk_gen_chk u_audclk_gen_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .half_rate(half_rate),
    .wide_pair(wide_pair),
    .ena_512  (ena_512),
    .ena_256  (ena_256),
    .ena_128  (ena_128),
    .ena_fs   (ena_fs),
    .lr_frame (lr_frame)
);

// File: tb/tb_audclk_gen.sv
// Scoreboard bench: the driver pushes per-mode expectations, the monitor
// measures a window of master cycles and compares.
module tb_audclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       half_rate = 1'b0;
    logic       wide_pair = 1'b0;
    logic       ena_512, ena_256, ena_128, ena_fs, lr_frame, pair_lo, pair_hi;

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    int cycles = 0;

    typedef struct {
        string tag;
        int win, e256, e128, e512, efs, elo, ehi, gap;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    audclk_gen dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .half_rate(half_rate),
        .wide_pair(wide_pair), .ena_512(ena_512), .ena_256(ena_256),
        .ena_128(ena_128), .ena_fs(ena_fs), .lr_frame(lr_frame),
        .pair_lo(pair_lo), .pair_hi(pair_hi)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected ratio from the requirement table (R2, R4).
    function automatic void ratio_of(input int code, input bit half, output int n, output int d);
        case (code)
            1: begin n = 1875; d = 784; end
            2: begin n = 2145; d = 896; end
            3: begin n = 3375; d = 1024; end
            4: begin n = 2; d = 1; end
            default: begin n = 1125; d = 512; end
        endcase
        if (half) n = 2 * n;
    endfunction

    // Driver: apply a configuration, let it settle, push the expectation, wait for the monitor.
    task automatic run_mode(input int code, input bit half, input bit wide, input int reps, input string tag);
        int n, d, hits;
        exp_t e;
        bit x2;
        ratio_of(code, half, n, d);
        x2 = half && wide;
        @(negedge clk);
        rate_sel = 3'(code); half_rate = half; wide_pair = wide;
        repeat (6) @(negedge clk);
        hits = d * reps;
        e.tag  = tag;
        e.win  = n * reps;
        e.e256 = hits;
        e.e128 = hits / 2;
        e.e512 = x2 ? 2 * hits : 0;
        e.efs  = (hits % 256 == 0) ? hits / 256 : -1;
        e.elo  = x2 ? hits : hits / 2;
        e.ehi  = x2 ? 2 * hits : hits;
        e.gap  = n / d;
        sbq.push_back(e);
        begin
            int target = n_done + 1;
            wait (n_done == target);
        end
    endtask

    // Monitor: pop an expectation, count strobes over its window, compare.
    initial begin
        forever begin
            exp_t e;
            int c256, c128, c512, cfs, clo, chi, ctog, last, mgap;
            logic lr_prev;
            wait (sbq.size() > 0);
            e = sbq.pop_front();
            c256 = 0; c128 = 0; c512 = 0; cfs = 0; clo = 0; chi = 0; ctog = 0;
            last = -1; mgap = 1 << 30;
            lr_prev = lr_frame;
            for (int i = 0; i < e.win; i++) begin
                @(negedge clk);
                if (ena_256) begin
                    c256++;
                    if (last >= 0 && (i - last) < mgap) mgap = i - last;
                    last = i;
                end
                if (ena_128) c128++;
                if (ena_512) c512++;
                if (ena_fs)  cfs++;
                if (pair_lo) clo++;
                if (pair_hi) chi++;
                if (lr_frame != lr_prev) ctog++;
                lr_prev = lr_frame;
            end
            check({"R2/R4 ", e.tag}, "ena_256 count", c256, e.e256);
            check({"R3 ", e.tag}, "min 256 gap >= floor(N/D)", (mgap >= e.gap) ? 1 : 0, 1);
            check({"R6 ", e.tag}, "ena_128 count", c128, e.e128);
            check({"R9 ", e.tag}, "ena_512 count", c512, e.e512);
            check({"R8 ", e.tag}, "pair_lo count", clo, e.elo);
            check({"R8 ", e.tag}, "pair_hi count", chi, e.ehi);
            if (e.efs >= 0) check({"R7 ", e.tag}, "ena_fs count", cfs, e.efs);
            check({"R7 ", e.tag}, "lr toggles vs fs", ctog, cfs);
            n_done++;
        end
    end

    // Watchdog: a hung run is one failed check and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int sum_any;
        // R1: reset state.
        repeat (4) @(negedge clk);
        sum_any = int'(ena_512) + int'(ena_256) + int'(ena_128) + int'(ena_fs) +
                  int'(lr_frame) + int'(pair_lo) + int'(pair_hi);
        check("R1", "outputs high during reset", sum_any, 0);
        rst_n = 1'b1;

        // R2: full-rate modes, plain pair.
        run_mode(0, 0, 0, 1, "48k");
        run_mode(1, 0, 0, 1, "44k1");
        run_mode(2, 0, 0, 1, "44k056");
        run_mode(3, 0, 0, 1, "32k");
        // R9: wide select ignored without half-rate.
        run_mode(0, 0, 1, 1, "48k wide no-half");
        // R4/R8: half-rate modes, wide pair.
        run_mode(0, 1, 1, 1, "24k wide");
        run_mode(1, 1, 1, 1, "22k05 wide");
        run_mode(2, 1, 1, 1, "22k028 wide");
        run_mode(3, 1, 0, 1, "16k narrow");
        // R5/R7: synchronous modes over whole frames.
        run_mode(4, 0, 0, 1024, "sync");
        run_mode(4, 1, 1, 512, "sync half wide");
        // R5: strict alternation in synchronous mode.
        run_mode(4, 0, 0, 1, "sync settle");
        begin
            int pat = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                pat = (pat << 1) | int'(ena_256);
            end
            check("R5", "alternation pattern", (pat == 8'hAA || pat == 8'h55) ? 1 : 0, 1);
        end
        // R10: restart on a configuration change, then first pulse after 4 cycles.
        @(negedge clk);
        half_rate = 1'b1;
        @(negedge clk);
        sum_any = int'(ena_512) + int'(ena_256) + int'(ena_128) + int'(ena_fs);
        check("R10", "strobes in restart cycle", sum_any, 0);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check("R10", $sformatf("ena_256 at cycle %0d after restart", i),
                  int'(ena_256), (i == 4) ? 1 : 0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule